// File: doc/BRIEF.md
# Supervisory Clock-Stop and Mode Controller

This controller decides which non-free-running logic clocks of a small processor model may pulse, and which of three control sets currently owns the shared data paths. Four set/reset stop latches each mask the register pulse and the late-register pulse of one or more clock domains. Free-running pulses are never routed through it. A log flag and three one-hot mode flags give the control status. The three modes are sequence-counter, main-store and microstore.

The controller changes status in three steps. First it sets the stop latches. Then it takes exactly one dead cycle, in which the mode flags are written. Then it clears the stops that the new mode needs.

An error interrupt starts a built-in logout. The logout freezes the machine and stores the frozen storage and microstore registers to fixed addresses, one per cycle. It steps through sequence-counter mode, then main-store mode, then microstore mode. At the end it releases every stop.

The controller only issues a register-select code and an address for each store. The data paths themselves are outside the block.

Top module: `sup_ctl`

## Requirements
- R1: After reset every stop latch is clear, mode_o is 3'b100 (microstore), log_o, dead_o, busy_o and store_vld_o are 0.
- R2: The gated pulse outputs use these bit positions: bit 0 is CPU, bit 1 is common channel, bit 2 is main store, bit 3 is microstore. Each bit equals the matching input pulse (reg_pulse_i or late_pulse_i) unless it is blocked. The CPU bit is blocked by the CPU-I/O stop or by the storage-holdoff stop. The channel bit is blocked by the CPU-I/O stop only. The main-store bit is blocked by the main-store stop, and the microstore bit by the microstore stop.
- R3: While idle, norm_irq_i sets the CPU-I/O, microstore and main-store stops on the next cycle without any mode change, and hold_i sets the storage-holdoff stop. restart_i clears stop latches: bit 0 is CPU-I/O, bit 1 microstore, bit 2 main store, bit 3 storage holdoff. When a set and a clear meet in the same cycle, the set wins.
- R4: While idle, mode_req_i with mode_sel_i selects a new mode: 0 is sequence-counter, 1 is main-store, 2 is microstore. The cycle after the request, the CPU-I/O, microstore and main-store stops are set and dead_o is high for exactly that one cycle. In the following cycle mode_o shows the new mode. At the end of that cycle the CPU-I/O and main-store stops are cleared, and the microstore stop is cleared as well when the new mode is microstore. The controller is then idle again.
- R5: A mode request with mode_sel_i equal to 3 is ignored. The controller stays idle and mode_o does not change.
- R6: mode_o always has exactly one bit set: bit 0 sequence-counter, bit 1 main-store, bit 2 microstore.
- R7: While idle, err_irq_i starts a logout. The next cycle is a dead cycle with all three freeze stops set. After it, log_o is 1, mode_o is sequence-counter and the main-store stop is clear, while the CPU-I/O and microstore stops stay set.
- R8: In the three cycles after the logout dead cycle, the block issues stores with select codes 0, 1 and 2 (storage data, storage address, instruction address) to addresses 80, 84 and 88, in that order.
- R9: Next comes one cycle without a store, after which mode_o is main-store. Then five stores follow, with select codes 3 to 6 (microstore data groups 1 to 4) and select code 7 (microstore address), to addresses 92 to 108 in steps of 4. The microstore stop is cleared after the last of these stores.
- R10: Next come two cycles without a store. After the first, mode_o is microstore. After the second, all four stop latches and log_o are clear and the controller is idle.
- R11: While busy_o is high, err_irq_i, norm_irq_i, mode_req_i, hold_i and restart_i are ignored. A request that is still held when the controller is idle again is then taken. In idle the priority order is err_irq_i, then norm_irq_i, then mode_req_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_pulse_i | input | 1 | Basic register pulse to be gated |
| late_pulse_i | input | 1 | Basic late-register pulse to be gated |
| norm_irq_i | input | 1 | Normal supervisory interrupt (freeze) |
| err_irq_i | input | 1 | Error interrupt, starts a logout |
| mode_req_i | input | 1 | Mode-call request |
| mode_sel_i | input | 2 | Requested mode code |
| hold_i | input | 1 | Storage-holdoff stop request |
| restart_i | input | 4 | Per-latch restart conditions |
| dom_reg_o | output | 4 | Gated register pulse per domain |
| dom_late_o | output | 4 | Gated late-register pulse per domain |
| mode_o | output | 3 | One-hot control mode |
| log_o | output | 1 | Logout in progress flag |
| dead_o | output | 1 | Dead cycle indicator |
| busy_o | output | 1 | Status change in progress |
| store_vld_o | output | 1 | Logout store command valid |
| store_sel_o | output | SEL_W | Register select of the store |
| store_addr_o | output | ADDR_W | Store address |

## Verification
A stop latch that is wrongly set or cleared shows up in the gated pulse outputs in the very cycle it takes effect. The bench drives random pulse inputs, so such a fault is visible within a cycle or two. A sequencer that is out of step shows up as a store select, an address or a mode flag one cycle early or late, or as a dead cycle in the wrong place. A request accepted while busy shows up as an extra dead cycle. The reference model is compared against every output on every clock, so any of these faults is reported in the cycle where it first appears.

// File: rtl/sup_ctl_pkg.sv
package sup_ctl_pkg;
  localparam int N_STOP = 4;
  localparam int STOP_CPU  = 0;
  localparam int STOP_US   = 1;
  localparam int STOP_MS   = 2;
  localparam int STOP_HOLD = 3;

  localparam int N_DOM = 4;
  localparam int DOM_CPU  = 0;
  localparam int DOM_CHAN = 1;
  localparam int DOM_MS   = 2;
  localparam int DOM_US   = 3;

  localparam int N_MODE = 3;

  localparam logic [N_STOP-1:0] FREEZE =
    N_STOP'((1 << STOP_CPU) | (1 << STOP_US) | (1 << STOP_MS));

  typedef enum logic [1:0] {
    MODE_SEQ  = 2'd0,
    MODE_MS   = 2'd1,
    MODE_US   = 2'd2,
    MODE_NONE = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CH_DEAD,
    ST_CH_RST,
    ST_LO_DEAD,
    ST_LO_STORE,
    ST_LO_MSCALL,
    ST_LO_UCALL1,
    ST_LO_UCALL2
  } seq_e;

  // stops released once a new mode owns the data paths
  function automatic logic [N_STOP-1:0] restart_mask(mode_e m);
    logic [N_STOP-1:0] r;
    r = '0;
    r[STOP_CPU] = 1'b1;
    r[STOP_MS]  = 1'b1;
    if (m == MODE_US) r[STOP_US] = 1'b1;
    return r;
  endfunction

  // which stop latches block a given domain
  function automatic logic [N_STOP-1:0] dom_block(int d);
    logic [N_STOP-1:0] r;
    r = '0;
    case (d)
      DOM_CPU:  begin r[STOP_CPU] = 1'b1; r[STOP_HOLD] = 1'b1; end
      DOM_CHAN: r[STOP_CPU] = 1'b1;
      DOM_MS:   r[STOP_MS]  = 1'b1;
      default:  r[STOP_US]  = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sup_stop_latches.sv
module sup_stop_latches
  import sup_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_STOP-1:0] set_i,
  input  logic [N_STOP-1:0] clr_i,
  input  logic              reg_pulse_i,
  input  logic              late_pulse_i,
  output logic [N_DOM-1:0]  dom_reg_o,
  output logic [N_DOM-1:0]  dom_late_o
);
  logic [N_STOP-1:0] stop_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stop_q <= '0;
    else         stop_q <= (stop_q & ~clr_i) | set_i;
  end

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    logic blk;
    assign blk           = |(stop_q & dom_block(d));
    assign dom_reg_o[d]  = reg_pulse_i  & ~blk;
    assign dom_late_o[d] = late_pulse_i & ~blk;
  end
endmodule

// File: rtl/sup_mode_regs.sv
module sup_mode_regs
  import sup_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  mode_e             mode_i,
  input  logic              log_set_i,
  input  logic              log_clr_i,
  output logic [N_MODE-1:0] mode_o,
  output logic              log_o
);
  logic [N_MODE-1:0] mode_q;
  logic              log_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= N_MODE'(1) << MODE_US;
      log_q  <= 1'b0;
    end else begin
      if (wr_i)           mode_q <= N_MODE'(1) << mode_i;
      if (log_set_i)      log_q  <= 1'b1;
      else if (log_clr_i) log_q  <= 1'b0;
    end
  end

  assign mode_o = mode_q;
  assign log_o  = log_q;
endmodule

// File: rtl/sup_seq.sv
module sup_seq
  import sup_ctl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int LOG_BASE = 80,
  parameter int LOG_STEP = 4,
  parameter int N_MAIN   = 3,
  parameter int N_US     = 5,
  localparam int N_ST    = N_MAIN + N_US,
  localparam int IDX_W   = $clog2(N_ST)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              norm_irq_i,
  input  logic              err_irq_i,
  input  logic              mode_req_i,
  input  logic [1:0]        mode_sel_i,
  input  logic              hold_i,
  input  logic [N_STOP-1:0] restart_i,
  output logic [N_STOP-1:0] set_o,
  output logic [N_STOP-1:0] clr_o,
  output logic              mode_wr_o,
  output mode_e             mode_nxt_o,
  output logic              log_set_o,
  output logic              log_clr_o,
  output logic              dead_o,
  output logic              busy_o,
  output logic              store_vld_o,
  output logic [IDX_W-1:0]  store_sel_o,
  output logic [ADDR_W-1:0] store_addr_o
);
  seq_e             state_q, state_d;
  mode_e            tgt_q, tgt_d, req_mode;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign req_mode = mode_e'(mode_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tgt_q   <= MODE_US;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      idx_q   <= idx_d;
    end
  end

  always_comb begin
    state_d    = state_q;
    tgt_d      = tgt_q;
    idx_d      = idx_q;
    set_o      = '0;
    clr_o      = '0;
    mode_wr_o  = 1'b0;
    mode_nxt_o = MODE_SEQ;
    log_set_o  = 1'b0;
    log_clr_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        clr_o            = restart_i;
        set_o[STOP_HOLD] = hold_i;
        if (err_irq_i) begin
          set_o  |= FREEZE;
          state_d = ST_LO_DEAD;
        end else if (norm_irq_i) begin
          set_o  |= FREEZE;
        end else if (mode_req_i && req_mode != MODE_NONE) begin
          set_o  |= FREEZE;
          tgt_d   = req_mode;
          state_d = ST_CH_DEAD;
        end
      end
      ST_CH_DEAD: begin
        mode_wr_o  = 1'b1;
        mode_nxt_o = tgt_q;
        state_d    = ST_CH_RST;
      end
      ST_CH_RST: begin
        clr_o   = restart_mask(tgt_q);
        state_d = ST_IDLE;
      end
      ST_LO_DEAD: begin
        log_set_o       = 1'b1;
        mode_wr_o       = 1'b1;
        mode_nxt_o      = MODE_SEQ;
        clr_o[STOP_MS]  = 1'b1;
        idx_d           = '0;
        state_d         = ST_LO_STORE;
      end
      ST_LO_STORE: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == IDX_W'(N_MAIN - 1)) begin
          state_d = ST_LO_MSCALL;
        end else if (idx_q == IDX_W'(N_ST - 1)) begin
          clr_o[STOP_US] = 1'b1;
          state_d        = ST_LO_UCALL1;
        end
      end
      ST_LO_MSCALL: begin
        mode_wr_o  = 1'b1;
        mode_nxt_o = MODE_MS;
        state_d    = ST_LO_STORE;
      end
      ST_LO_UCALL1: begin
        mode_wr_o  = 1'b1;
        mode_nxt_o = MODE_US;
        state_d    = ST_LO_UCALL2;
      end
      default: begin
        clr_o     = '1;
        log_clr_o = 1'b1;
        idx_d     = '0;
        state_d   = ST_IDLE;
      end
    endcase
  end

  assign dead_o       = (state_q == ST_CH_DEAD) || (state_q == ST_LO_DEAD);
  assign busy_o       = (state_q != ST_IDLE);
  assign store_vld_o  = (state_q == ST_LO_STORE);
  assign store_sel_o  = idx_q;
  assign store_addr_o = ADDR_W'(LOG_BASE) + ADDR_W'(LOG_STEP) * ADDR_W'(idx_q);
endmodule

// File: rtl/sup_ctl.sv
module sup_ctl
  import sup_ctl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int LOG_BASE = 80,
  parameter int LOG_STEP = 4,
  parameter int N_MAIN   = 3,
  parameter int N_US     = 5,
  localparam int SEL_W   = $clog2(N_MAIN + N_US)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_pulse_i,
  input  logic              late_pulse_i,
  input  logic              norm_irq_i,
  input  logic              err_irq_i,
  input  logic              mode_req_i,
  input  logic [1:0]        mode_sel_i,
  input  logic              hold_i,
  input  logic [3:0]        restart_i,
  output logic [3:0]        dom_reg_o,
  output logic [3:0]        dom_late_o,
  output logic [2:0]        mode_o,
  output logic              log_o,
  output logic              dead_o,
  output logic              busy_o,
  output logic              store_vld_o,
  output logic [SEL_W-1:0]  store_sel_o,
  output logic [ADDR_W-1:0] store_addr_o
);
  logic [N_STOP-1:0] stop_set, stop_clr;
  logic              mode_wr, log_set, log_clr;
  mode_e             mode_nxt;

  sup_seq #(
    .ADDR_W  (ADDR_W),
    .LOG_BASE(LOG_BASE),
    .LOG_STEP(LOG_STEP),
    .N_MAIN  (N_MAIN),
    .N_US    (N_US)
  ) seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .norm_irq_i  (norm_irq_i),
    .err_irq_i   (err_irq_i),
    .mode_req_i  (mode_req_i),
    .mode_sel_i  (mode_sel_i),
    .hold_i      (hold_i),
    .restart_i   (restart_i),
    .set_o       (stop_set),
    .clr_o       (stop_clr),
    .mode_wr_o   (mode_wr),
    .mode_nxt_o  (mode_nxt),
    .log_set_o   (log_set),
    .log_clr_o   (log_clr),
    .dead_o      (dead_o),
    .busy_o      (busy_o),
    .store_vld_o (store_vld_o),
    .store_sel_o (store_sel_o),
    .store_addr_o(store_addr_o)
  );

  sup_stop_latches stops_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (stop_set),
    .clr_i       (stop_clr),
    .reg_pulse_i (reg_pulse_i),
    .late_pulse_i(late_pulse_i),
    .dom_reg_o   (dom_reg_o),
    .dom_late_o  (dom_late_o)
  );

  sup_mode_regs mode_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (mode_wr),
    .mode_i   (mode_nxt),
    .log_set_i(log_set),
    .log_clr_i(log_clr),
    .mode_o   (mode_o),
    .log_o    (log_o)
  );
endmodule

// File: rtl/sup_ctl_chk.sv
module sup_ctl_chk #(
  parameter int ADDR_W   = 8,
  parameter int LOG_BASE = 80,
  parameter int SEL_W    = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              err_irq_i,
  input logic [3:0]        dom_reg_o,
  input logic [3:0]        dom_late_o,
  input logic [2:0]        mode_o,
  input logic              log_o,
  input logic              dead_o,
  input logic              busy_o,
  input logic              store_vld_o,
  input logic [SEL_W-1:0]  store_sel_o,
  input logic [ADDR_W-1:0] store_addr_o
);
  assert_dead_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |-> (dom_reg_o == 4'b0) && (dom_late_o == 4'b0));

  assert_dead_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |=> !dead_o);

  assert_mode_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mode_o) == 1);

  assert_chan_follows_cpu_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dom_reg_o[0] |-> dom_reg_o[1]) and (dom_late_o[0] |-> dom_late_o[1]));

  assert_err_dead_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && err_irq_i) |=> dead_o);

  assert_log_seq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(log_o) |-> mode_o == 3'b001);

  assert_first_store_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_vld_o && $past(dead_o)) |->
      (store_sel_o == '0) && (store_addr_o == ADDR_W'(LOG_BASE)));

  assert_store_in_log_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_vld_o |-> log_o && busy_o);
endmodule

bind sup_ctl sup_ctl_chk #(
  .ADDR_W  (ADDR_W),
  .LOG_BASE(LOG_BASE),
  .SEL_W   (SEL_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .err_irq_i   (err_irq_i),
  .dom_reg_o   (dom_reg_o),
  .dom_late_o  (dom_late_o),
  .mode_o      (mode_o),
  .log_o       (log_o),
  .dead_o      (dead_o),
  .busy_o      (busy_o),
  .store_vld_o (store_vld_o),
  .store_sel_o (store_sel_o),
  .store_addr_o(store_addr_o)
);

// File: tb/sup_ctl_tb_top.sv
`timescale 1ns/1ps
module sup_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_pulse = 1'b0, late_pulse = 1'b0;
  logic       norm_irq = 1'b0, err_irq = 1'b0, mode_req = 1'b0, hold = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [3:0] restart = 4'd0;
  logic [3:0] dom_reg, dom_late;
  logic [2:0] mode;
  logic       log_f, dead, busy, st_vld;
  logic [2:0] st_sel;
  logic [7:0] st_addr;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sup_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .reg_pulse_i(reg_pulse), .late_pulse_i(late_pulse),
    .norm_irq_i(norm_irq), .err_irq_i(err_irq), .mode_req_i(mode_req),
    .mode_sel_i(mode_sel), .hold_i(hold), .restart_i(restart),
    .dom_reg_o(dom_reg), .dom_late_o(dom_late), .mode_o(mode), .log_o(log_f),
    .dead_o(dead), .busy_o(busy), .store_vld_o(st_vld), .store_sel_o(st_sel),
    .store_addr_o(st_addr)
  );

  // reference model: stop bits 0 cpu-io, 1 microstore, 2 main store, 3 holdoff
  logic [3:0] m_stop = 4'd0;
  int m_mode = 2, m_log = 0, m_kind = 0, m_step = 0, m_tgt = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_stop = 4'd0; m_mode = 2; m_log = 0; m_kind = 0; m_step = 0;
    end else if (m_kind == 0) begin
      logic [3:0] s;
      s = {hold, 3'b000};
      if (err_irq) begin s |= 4'b0111; m_kind = 2; m_step = 1; end
      else if (norm_irq) s |= 4'b0111;
      else if (mode_req && mode_sel != 2'd3) begin
        s |= 4'b0111; m_kind = 1; m_step = 1; m_tgt = int'(mode_sel);
      end
      m_stop = (m_stop & ~restart) | s;
    end else if (m_kind == 1) begin
      if (m_step == 1) begin m_mode = m_tgt; m_step = 2; end
      else begin
        m_stop &= (m_tgt == 2) ? 4'b1000 : 4'b1010;
        m_kind = 0;
      end
    end else begin
      case (m_step)
        1:  begin m_log = 1; m_mode = 0; m_stop[2] = 1'b0; end
        5:  m_mode = 1;
        10: m_stop[1] = 1'b0;
        11: m_mode = 2;
        12: begin m_stop = 4'd0; m_log = 0; m_kind = 0; end
        default: ;
      endcase
      m_step++;
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      logic [3:0] blk;
      int vld, sel;
      blk[0] = m_stop[0] | m_stop[3];
      blk[1] = m_stop[0];
      blk[2] = m_stop[2];
      blk[3] = m_stop[1];
      cmp("R2 dom_reg", dom_reg, {4{reg_pulse}} & ~blk);
      cmp("R2 dom_late", dom_late, {4{late_pulse}} & ~blk);
      cmp("R6 mode", mode, 1 << m_mode);
      cmp("R7 log", log_f, m_log);
      cmp("R4 dead", dead, (m_kind != 0 && m_step == 1));
      cmp("R11 busy", busy, m_kind != 0);
      vld = (m_kind == 2) && ((m_step >= 2 && m_step <= 4) || (m_step >= 6 && m_step <= 10));
      cmp("R8 store_vld", st_vld, vld);
      if (vld != 0) begin
        sel = (m_step <= 4) ? m_step - 2 : m_step - 3;
        cmp("R9 store_sel", st_sel, sel);
        cmp("R9 store_addr", st_addr, 80 + 4 * sel);
      end
    end
  end

  // random pulse inputs, driven off the edges
  always @(negedge clk) begin
    #0.5;
    reg_pulse  = 1'($urandom_range(0, 1));
    late_pulse = 1'($urandom_range(0, 1));
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #0.5;
    end
  endtask

  task automatic do_change(input logic [1:0] sel, input int exp_oh);
    mode_sel = sel; mode_req = 1'b1;
    cyc(); mode_req = 1'b0;
    cmp("R4 dead after request", dead, 1);
    cyc();
    cmp("R4 mode written", mode, exp_oh);
    cmp("R4 still busy", busy, 1);
    cyc();
    cmp("R4 back to idle", busy, 0);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1'b1;
    report();
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc();
    cmp("R1 mode", mode, 4);
    cmp("R1 log", log_f, 0);
    cmp("R1 busy", busy, 0);
    cmp("R1 dead", dead, 0);
    cmp("R1 store", st_vld, 0);
    cyc(2);

    do_change(2'd0, 1);
    do_change(2'd1, 2);
    do_change(2'd2, 4);

    // R5 code 3 ignored
    mode_sel = 2'd3; mode_req = 1'b1;
    cyc(); mode_req = 1'b0;
    cmp("R5 busy", busy, 0);
    cmp("R5 dead", dead, 0);
    cyc();
    cmp("R5 mode", mode, 4);

    // R3 normal freeze and restarts
    norm_irq = 1'b1; cyc(); norm_irq = 1'b0;
    cmp("R3 no sequence", busy, 0);
    cyc(3);
    restart = 4'b0100; cyc();
    restart = 4'b0001; hold = 1'b1; cyc();
    restart = 4'b1010; cyc();
    restart = 4'b0000; hold = 1'b0; cyc(2);
    restart = 4'b1000; cyc(); restart = 4'b0000;
    cyc(2);

    // R7-R10 logout, requests held during it (R11)
    err_irq = 1'b1; cyc(); err_irq = 1'b0;
    cmp("R7 dead", dead, 1);
    cyc();
    cmp("R7 log set", log_f, 1);
    cmp("R7 seq mode", mode, 1);
    norm_irq = 1'b1; mode_sel = 2'd1; mode_req = 1'b1;
    restart = 4'b0010; hold = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cmp("R8 store valid", st_vld, 1);
      cmp("R8 store sel", st_sel, k);
      cmp("R8 store addr", st_addr, 80 + 4 * k);
      cyc();
    end
    cmp("R9 gap", st_vld, 0);
    cmp("R11 held off", dead, 0);
    cyc();
    cmp("R9 ms mode", mode, 2);
    for (int k = 3; k < 8; k++) begin
      cmp("R9 store sel", st_sel, k);
      cmp("R9 store addr", st_addr, 80 + 4 * k);
      cyc();
    end
    restart = 4'b0000; hold = 1'b0;
    cmp("R10 no store", st_vld, 0);
    cyc();
    cmp("R10 us mode", mode, 4);
    cyc();
    cmp("R10 idle", busy, 0);
    cmp("R10 log clear", log_f, 0);
    cyc();
    cmp("R11 norm before mode req", busy, 0);
    norm_irq = 1'b0;
    cyc();
    cmp("R11 held request taken", dead, 1);
    mode_req = 1'b0;
    cyc(3);

    // R11 error held off during a change
    mode_sel = 2'd0; mode_req = 1'b1; cyc(); mode_req = 1'b0;
    err_irq = 1'b1; cyc();
    cmp("R11 err ignored busy", dead, 0);
    cyc(); cyc();
    cmp("R11 err taken at idle", dead, 1);
    err_irq = 1'b0;
    cyc(14);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      err_irq  = ($urandom_range(0, 99) < 2);
      norm_irq = ($urandom_range(0, 99) < 4);
      mode_req = ($urandom_range(0, 99) < 10);
      mode_sel = 2'($urandom_range(0, 3));
      hold     = ($urandom_range(0, 99) < 5);
      restart  = ($urandom_range(0, 99) < 30) ? 4'($urandom_range(0, 15)) : 4'd0;
      cyc();
    end
    err_irq = 1'b0; norm_irq = 1'b0; mode_req = 1'b0; hold = 1'b0; restart = 4'd0;
    cyc(20);
    done = 1'b1;
    report();
  end
endmodule